// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block turns a grayscale pixel stream into an edge-strength stream. Pixels arrive one per accepted cycle in raster order, meaning left to right along a row and then row by row downward. A start flag marks the first pixel of each frame. The block keeps the two rows above the current pixel in two internal line buffers. It slides a 3x3 window across the frame and, for every window that lies wholly inside the image, emits one output pixel. Each output is the sum of the absolute horizontal and vertical Sobel gradients, limited to half of full scale.

Frame width and height are inputs that may change between frames, up to the sizes set by parameters (160 by 120 by default). The input may idle between pixels. The output carries a registered valid, the edge value, and an end-of-frame marker on the final result. Downstream logic cannot stall the output, so it must accept every result.

Top module: `sobel_stream`

## Requirements
- R1: For a W x H frame (W, H at least 3) the block emits exactly (W-2)*(H-2) results, in raster order of their window centres.
- R2: For the window centred on row r, column c, gx = (p[r-1][c+1] + 2*p[r][c+1] + p[r+1][c+1]) - (p[r-1][c-1] + 2*p[r][c-1] + p[r+1][c-1]) and gy = (p[r+1][c-1] + 2*p[r+1][c] + p[r+1][c+1]) - (p[r-1][c-1] + 2*p[r-1][c] + p[r-1][c+1]). The result is |gx|+|gy| when that sum is 127 or less.
- R3: When |gx|+|gy| exceeds 127 (half of the 8-bit maximum, rounded down), the result is exactly 127.
- R4: A result appears at the second rising edge counting the edge that accepts the pixel completing its window. outValid is high for exactly that one cycle.
- R5: Pixels in rows 0 and 1 of a frame, and in columns 0 and 1 of any row, produce no result.
- R6: A pixel accepted with pixSof high is treated as row 0, column 0, even if a frame is still in progress. Results already earned by the interrupted frame are still emitted.
- R7: outEof is high only together with the result of the window whose completing pixel is at row H-1, column W-1, and never with any other result.
- R8: Valid pixels that arrive without pixSof, either after reset before any start or after a frame's last pixel, are ignored and produce no result.
- R9: During and after reset, until a result is produced, outValid and outEof are low and outData is 0. Whenever outValid is low, outData is 0.
- R10: Idle cycles with pixValid low may appear anywhere in the input. Results then depend only on the pixel values and positions, and each keeps its R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| widthIn | input | 8 | Frame width in pixels, 3 to MAX_W, held stable during a frame |
| heightIn | input | 7 | Frame height in rows, 3 to MAX_H, held stable during a frame |
| pixValid | input | 1 | Input pixel present this cycle |
| pixSof | input | 1 | With pixValid: this pixel is row 0, column 0 |
| pixData | input | 8 | Unsigned grayscale input pixel |
| outValid | output | 1 | Result present this cycle |
| outData | output | 8 | Clamped edge magnitude, 0 to 127 |
| outEof | output | 1 | Marks the last result of a frame |

## Verification
A wrong row or column counter shows up at once as a result in a border position, a missing result, or an end flag on the wrong pixel. Any of these is visible at the latest at the end of the affected row, and the missing or surplus result count is visible at frame end. Corrupt line-buffer or window contents surface two cycles after the first affected window is completed, as a value mismatch against a model of the kernels. The checks compare every result for value, arrival cycle and end flag. They use smooth gradients, a constant field, clamping stripes, hashed data with random input gaps, a frame cut short by a new start, and stray pixels outside any frame.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  // strobes from the control to the datapath, valid in the cycle of the pixel
  typedef struct packed {
    logic shift;  // accept pixel: shift window, update line buffers
    logic emit;   // window completed by this pixel is interior
    logic last;   // this interior window is the final one of the frame
  } ctrlStrobe_t;
endpackage

// File: rtl/sobel_ctrl.sv
module sobel_ctrl
  import sobel_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic [COL_W-1:0] widthIn,
  input  logic [ROW_W-1:0] heightIn,
  output ctrlStrobe_t      strobe,
  output logic [COL_W-1:0] colIdx
);
  logic [COL_W-1:0] colCnt, effCol;
  logic [ROW_W-1:0] rowCnt, effRow;
  logic active, take, rowEnd, frameEnd;

  always_comb begin
    take     = pixValid && (pixSof || active);
    effCol   = pixSof ? '0 : colCnt;
    effRow   = pixSof ? '0 : rowCnt;
    rowEnd   = (effCol == widthIn - COL_W'(1));
    frameEnd = rowEnd && (effRow == heightIn - ROW_W'(1));
    strobe.shift = take;
    strobe.emit  = take && (effRow >= ROW_W'(2)) && (effCol >= COL_W'(2));
    strobe.last  = take && (effRow >= ROW_W'(2)) && (effCol >= COL_W'(2)) && frameEnd;
    colIdx = effCol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colCnt <= '0;
      rowCnt <= '0;
      active <= 1'b0;
    end else if (take) begin
      if (frameEnd) begin
        colCnt <= '0;
        rowCnt <= '0;
        active <= 1'b0;
      end else begin
        active <= 1'b1;
        colCnt <= rowEnd ? '0 : effCol + COL_W'(1);
        rowCnt <= rowEnd ? effRow + ROW_W'(1) : effRow;
      end
    end
  end
endmodule

// File: rtl/sobel_dp.sv
module sobel_dp
  import sobel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 160,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] pixData,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outEof
);
  localparam int ACC_W = PIX_W + 4;
  localparam logic [ACC_W-1:0] CLAMP = ACC_W'((1 << PIX_W) / 2 - 1);

  logic [PIX_W-1:0] lineUp1 [MAX_W];  // row r-1
  logic [PIX_W-1:0] lineUp2 [MAX_W];  // row r-2
  logic [PIX_W-1:0] win [3][3];       // [row][col], col 2 newest
  logic [PIX_W-1:0] newCol [3];
  logic s1Emit, s1Last;

  always_comb begin
    newCol[0] = lineUp2[colIdx];
    newCol[1] = lineUp1[colIdx];
    newCol[2] = pixData;
  end

  always_ff @(posedge clk) begin
    if (strobe.shift) begin
      lineUp2[colIdx] <= lineUp1[colIdx];
      lineUp1[colIdx] <= pixData;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_winRow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[i][0] <= '0;
        win[i][1] <= '0;
        win[i][2] <= '0;
      end else if (strobe.shift) begin
        win[i][0] <= win[i][1];
        win[i][1] <= win[i][2];
        win[i][2] <= newCol[i];
      end
    end
  end

  // gradient arithmetic on the registered window
  logic signed [ACC_W-1:0] e [3][3];
  logic signed [ACC_W-1:0] gx, gy;
  logic [ACC_W-1:0] ax, ay, mag;
  logic [PIX_W-1:0] result;

  for (genvar i = 0; i < 3; i++) begin : g_extR
    for (genvar j = 0; j < 3; j++) begin : g_extC
      assign e[i][j] = $signed({{(ACC_W-PIX_W){1'b0}}, win[i][j]});
    end
  end

  always_comb begin
    gx = (e[0][2] + (e[1][2] <<< 1) + e[2][2]) - (e[0][0] + (e[1][0] <<< 1) + e[2][0]);
    gy = (e[2][0] + (e[2][1] <<< 1) + e[2][2]) - (e[0][0] + (e[0][1] <<< 1) + e[0][2]);
    ax = gx[ACC_W-1] ? ACC_W'(-gx) : ACC_W'(gx);
    ay = gy[ACC_W-1] ? ACC_W'(-gy) : ACC_W'(gy);
    mag = ax + ay;
    result = (mag > CLAMP) ? CLAMP[PIX_W-1:0] : mag[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Emit   <= 1'b0;
      s1Last   <= 1'b0;
      outValid <= 1'b0;
      outEof   <= 1'b0;
      outData  <= '0;
    end else begin
      s1Emit   <= strobe.emit;
      s1Last   <= strobe.last;
      outValid <= s1Emit;
      outEof   <= s1Last;
      outData  <= s1Emit ? result : '0;
    end
  end
endmodule

// File: rtl/sobel_stream.sv
module sobel_stream
  import sobel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 160,
  parameter int MAX_H = 120,
  localparam int COL_W = $clog2(MAX_W + 1),
  localparam int ROW_W = $clog2(MAX_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] widthIn,
  input  logic [ROW_W-1:0] heightIn,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic [PIX_W-1:0] pixData,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outEof
);
  ctrlStrobe_t      strobe;
  logic [COL_W-1:0] colIdx;

  sobel_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .pixSof(pixSof),
    .widthIn(widthIn), .heightIn(heightIn), .strobe(strobe), .colIdx(colIdx)
  );

  sobel_dp #(.PIX_W(PIX_W), .MAX_W(MAX_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .colIdx(colIdx),
    .pixData(pixData), .outValid(outValid), .outData(outData), .outEof(outEof)
  );
endmodule

// File: rtl/sobel_checker.sv
module sobel_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pixValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outData,
  input logic             outEof
);
  localparam logic [PIX_W-1:0] LIMIT = PIX_W'((1 << PIX_W) / 2 - 1);

  // R3: results never exceed half scale
  a_r3_clamp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outData <= LIMIT);

  // R7: end marker only rides on a result
  a_r7_eof_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    outEof |-> outValid);

  // R7: nothing follows the last result in the next cycle
  a_r7_eof_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    outEof |=> !outValid);

  // R9: idle output carries zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> outData == '0);

  // R4: every result traces back to a pixel two edges earlier
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(pixValid, 2));
endmodule

bind sobel_stream sobel_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pixValid(pixValid),
  .outValid(outValid), .outData(outData), .outEof(outEof)
);

// File: tb/sim_sobel_stream.sv
module sim_sobel_stream;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] widthIn = 8'd3;
  logic [6:0] heightIn = 7'd3;
  logic       pixValid = 1'b0;
  logic       pixSof = 1'b0;
  logic [7:0] pixData = 8'd0;
  logic       outValid;
  logic [7:0] outData;
  logic       outEof;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int got = 0;
  logic [15:0] lfsr = 16'hACE1;

  int qData[$];
  int qCyc[$];
  bit qEof[$];

  sobel_stream u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pixAt(int r, int c, int mode);
    case (mode)
      0: return (c * 3 + r) & 255;
      1: return ((r * 97) ^ (c * 53)) + r * c & 255;
      2: return 50;
      default: return ((c % 4) < 2) ? 255 : 0;
    endcase
  endfunction

  // model: window completed by pixel (r,c), centred on (r-1,c-1)
  function automatic int expOut(int r, int c, int mode);
    int p[3][3];
    int gx, gy, s;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        p[i][j] = pixAt(r - 2 + i, c - 2 + j, mode);
    gx = p[0][2] + 2 * p[1][2] + p[2][2] - p[0][0] - 2 * p[1][0] - p[2][0];
    gy = p[2][0] + 2 * p[2][1] + p[2][2] - p[0][0] - 2 * p[0][1] - p[0][2];
    s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (s > 127) ? 127 : s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare every result with the model queue
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      got++;
      if (qData.size() == 0) begin
        check(1'b0, "R8/R1 unexpected result", outData, -1);
      end else begin
        int d, t;
        bit f;
        d = qData.pop_front();
        t = qCyc.pop_front();
        f = qEof.pop_front();
        check(outData == 8'(d), "R2/R3 data", outData, d);
        check(cyc == t, "R4 latency cycle", cyc, t);
        check(outEof == f, "R7 eof", outEof, f);
      end
    end
  end

  // drives a frame; sofOn=0 sends stray pixels expected to be ignored
  task automatic driveFrame(int w, int h, int mode, bit gaps, int limit, bit sofOn);
    int n = 0;
    widthIn = 8'(w);
    heightIn = 7'(h);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        if (n >= limit) return;
        if (gaps) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          if (lfsr[0]) begin
            pixValid = 1'b0;
            @(negedge clk);
          end
        end
        pixValid = 1'b1;
        pixSof = sofOn && (r == 0) && (c == 0);
        pixData = 8'(pixAt(r, c, mode));
        if (sofOn && r >= 2 && c >= 2) begin
          qData.push_back(expOut(r, c, mode));
          qCyc.push_back(cyc + 2);
          qEof.push_back((r == h - 1) && (c == w - 1));
        end
        n++;
        @(negedge clk);
        pixValid = 1'b0;
        pixSof = 1'b0;
      end
    end
  endtask

  task automatic drainAndCount(string req, int startGot, int expCount);
    repeat (6) @(negedge clk);
    check(qData.size() == 0, {req, " all results arrived"}, qData.size(), 0);
    check(got - startGot == expCount, {req, " result count"}, got - startGot, expCount);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!outValid && !outEof && outData == 0, "R9 in reset", {outValid, outEof, outData}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !outEof && outData == 0, "R9 after reset", {outValid, outEof, outData}, 0);
  endtask

  task automatic testStrayBeforeStart();
    int g = got;
    driveFrame(6, 4, 1, 1'b0, 1000, 1'b0);  // R8: no start flag yet
    drainAndCount("R8 stray before start", g, 0);
  endtask

  task automatic testMinimal();
    int g = got;
    driveFrame(3, 3, 1, 1'b0, 1000, 1'b1);  // R1 R7: single interior result
    drainAndCount("R1 3x3 frame", g, 1);
  endtask

  task automatic testRampFull();
    int g = got;
    driveFrame(160, 120, 0, 1'b0, 1 << 20, 1'b1);  // R10 R2 R5 full size
    drainAndCount("R10 160x120 ramp", g, 158 * 118);
  endtask

  task automatic testFlat();
    int g = got;
    driveFrame(9, 5, 2, 1'b0, 1000, 1'b1);  // R2: constant gives 0
    drainAndCount("R2 flat field", g, 7 * 3);
  endtask

  task automatic testClamp();
    int g = got;
    driveFrame(12, 6, 3, 1'b0, 1000, 1'b1);  // R3 stripes saturate
    drainAndCount("R3 stripes", g, 10 * 4);
  endtask

  task automatic testGaps();
    int g = got;
    driveFrame(23, 9, 1, 1'b1, 1000, 1'b1);  // R10 idle cycles between pixels
    drainAndCount("R10 gapped hash", g, 21 * 7);
  endtask

  task automatic testRestart();
    int g = got;
    driveFrame(8, 6, 1, 1'b0, 30, 1'b1);  // R6: cut after 30 pixels
    driveFrame(7, 5, 0, 1'b1, 1000, 1'b1);
    drainAndCount("R6 restart mid-frame", g, 6 + 4 + 5 * 3);
  endtask

  task automatic testStrayAfterFrame();
    int g = got;
    driveFrame(5, 4, 1, 1'b0, 1000, 1'b1);
    drainAndCount("R7 frame before stray", g, 3 * 2);
    g = got;
    driveFrame(5, 4, 0, 1'b0, 1000, 1'b0);  // R8: after last pixel, no start
    drainAndCount("R8 stray after frame", g, 0);
  endtask

  initial begin
    testReset();
    testStrayBeforeStart();
    testMinimal();
    testFlat();
    testClamp();
    testGaps();
    testRestart();
    testStrayAfterFrame();
    testRampFull();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule